// File: doc/BRIEF.md
# Two-Stream Sample-Number Aligner

This block lines up two receive sample streams that come from separate boards sharing a locked clock. Each input beat carries a whole frame. The first complex word of the frame holds a free-running 32-bit sample number: the upper 16 bits sit in the I half and the lower 16 bits in the Q half. One or two complex data channels follow it. The block rebuilds both sample numbers and compares them. While they differ, it throws away frames from the stream that is behind and holds the other stream. When the numbers agree, it hands both frames to a registered output together.

A downstream consumer sees pairs of frames that carry the same sample number, so it can treat the two boards as one phase-coherent receiver. Each output frame keeps its counter word in channel 0, and its data channels follow in their original positions. An interval parameter is accepted for future periodic realignment. It has no effect on behaviour.

Frame layout: channel k occupies bits [k*2*SW +: 2*SW]. Within a channel, I is the upper SW bits and Q is the lower SW bits. The sample number is therefore bits [2*SW-1:0] of the frame.

Top module: `stream_align`

## Requirements
- R1: While `rst` is high, `a_ready` and `b_ready` are 0. After reset, `o_valid` and `o_locked` are 0.
- R2: When both inputs are valid with equal sample numbers and the output register can load (empty, or `o_ready` high), both readies are 1. On the next cycle `o_valid` is 1, and `o_frame_a` and `o_frame_b` equal the accepted input frames bit for bit.
- R3: When both inputs are valid and stream A's sample number is behind, `a_ready` is 1 and `b_ready` is 0. The A frame is discarded and no output is produced from it. This happens whether or not the output is stalled.
- R4: When both inputs are valid and stream B's sample number is behind, `b_ready` is 1 and `a_ready` is 0. The B frame is discarded.
- R5: "Behind" means the 32-bit difference A minus B, taken modulo 2^32, has its top bit set. For example, 0xFFFFFFF0 is behind 0x00000005.
- R6: If only one input is valid, neither ready is asserted and nothing is emitted.
- R7: While `o_valid` is 1 and `o_ready` is 0, the output frames hold their values and matched frames are not accepted.
- R8: `o_locked` becomes 1 after a matched pair is accepted. It returns to 0 in the cycle after a frame is discarded for a mismatch.
- R9: With random valids, random output backpressure and streams that start at different offsets with gaps, the emitted pairs are exactly the sequence of equal sample numbers that a two-pointer merge of the two streams yields, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Stream A frame present |
| a_ready | output | 1 | Stream A frame taken (matched or discarded) |
| a_frame | input | FW | Stream A frame, counter in channel 0 |
| b_valid | input | 1 | Stream B frame present |
| b_ready | output | 1 | Stream B frame taken (matched or discarded) |
| b_frame | input | FW | Stream B frame, counter in channel 0 |
| o_valid | output | 1 | Aligned pair present |
| o_ready | input | 1 | Consumer takes the aligned pair |
| o_frame_a | output | FW | Aligned frame from stream A |
| o_frame_b | output | FW | Aligned frame from stream B |
| o_locked | output | 1 | Last decision was a match |

## Verification
Several properties are checked on every cycle. Readies appear only when both inputs are valid. Every accepted pair emerges on the next cycle with equal counters. The output holds still under backpressure. A discard clears the lock flag. Only the bench scenarios can show which side is dropped for a given lag, including across the 32-bit wrap, and that the full merged sequence of pairs comes out complete and in order under random traffic.

// File: rtl/stream_align_pkg.sv
package stream_align_pkg;
  // Outcome of comparing the two sample numbers
  typedef enum logic [1:0] {
    LAG_NONE = 2'd0,
    LAG_A    = 2'd1,
    LAG_B    = 2'd2
  } lag_e;
endpackage

// File: rtl/sa_ctr_join.sv
// Rebuilds the sample number from channel 0 of a frame (I = upper half, Q = lower half)
module sa_ctr_join #(
  parameter int SW = 16,
  parameter int FW = 96
) (
  input  logic [FW-1:0]   frame,
  output logic [2*SW-1:0] count
);
  logic [SW-1:0] hi_i, lo_q;
  assign hi_i  = frame[2*SW-1:SW];
  assign lo_q  = frame[SW-1:0];
  assign count = {hi_i, lo_q};
endmodule

// File: rtl/sa_lag_cmp.sv
// Decides which stream is behind using the sign of the modular difference
module sa_lag_cmp
  import stream_align_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic [CW-1:0] cnt_a,
  input  logic [CW-1:0] cnt_b,
  output lag_e          lag
);
  logic [CW-1:0] diff;
  assign diff = cnt_a - cnt_b;

  always_comb begin
    if (diff == '0)      lag = LAG_NONE;
    else if (diff[CW-1]) lag = LAG_A;
    else                 lag = LAG_B;
  end
endmodule

// File: rtl/sa_out_reg.sv
// Registered output stage holding one aligned pair
module sa_out_reg #(
  parameter int FW = 96
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] in_a,
  input  logic [FW-1:0] in_b,
  input  logic          o_ready,
  output logic          can_load,
  output logic          o_valid,
  output logic [FW-1:0] o_frame_a,
  output logic [FW-1:0] o_frame_b
);
  assign can_load = !o_valid || o_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
    end else if (load) begin
      o_valid <= 1'b1;
    end else if (o_ready) begin
      o_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      o_frame_a <= in_a;
      o_frame_b <= in_b;
    end
  end

  // Output pair must not move while the consumer stalls
  assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_frame_a) && $stable(o_frame_b)));
endmodule

// File: rtl/stream_align.sv
module stream_align
  import stream_align_pkg::*;
#(
  parameter int SW        = 16,
  parameter int NDATA     = 2,
  parameter int ALIGN_IVL = 0,
  localparam int NCH      = NDATA + 1,
  localparam int FW       = 2 * SW * NCH,
  localparam int CW       = 2 * SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_valid,
  output logic          a_ready,
  input  logic [FW-1:0] a_frame,
  input  logic          b_valid,
  output logic          b_ready,
  input  logic [FW-1:0] b_frame,
  output logic          o_valid,
  input  logic          o_ready,
  output logic [FW-1:0] o_frame_a,
  output logic [FW-1:0] o_frame_b,
  output logic          o_locked
);
  if (NDATA < 1 || NDATA > 2 || ALIGN_IVL < 0) begin : g_bad_cfg
    $error("stream_align: NDATA must be 1 or 2 and ALIGN_IVL non-negative");
  end

  logic [FW-1:0] frames [2];
  logic [CW-1:0] counts [2];
  assign frames[0] = a_frame;
  assign frames[1] = b_frame;

  for (genvar s = 0; s < 2; s++) begin : g_join
    sa_ctr_join #(.SW(SW), .FW(FW)) u_join (
      .frame(frames[s]),
      .count(counts[s])
    );
  end

  lag_e lag;
  sa_lag_cmp #(.CW(CW)) u_cmp (
    .cnt_a(counts[0]),
    .cnt_b(counts[1]),
    .lag  (lag)
  );

  logic both, can_load, fire;
  assign both = a_valid && b_valid && !rst;
  assign fire = both && (lag == LAG_NONE) && can_load;

  assign a_ready = fire || (both && lag == LAG_A);
  assign b_ready = fire || (both && lag == LAG_B);

  sa_out_reg #(.FW(FW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (fire),
    .in_a     (a_frame),
    .in_b     (b_frame),
    .o_ready  (o_ready),
    .can_load (can_load),
    .o_valid  (o_valid),
    .o_frame_a(o_frame_a),
    .o_frame_b(o_frame_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      o_locked <= 1'b0;
    end else if (fire) begin
      o_locked <= 1'b1;
    end else if (both && lag != LAG_NONE) begin
      o_locked <= 1'b0;
    end
  end

  // Readies only when both sides offer a frame
  assert_no_one_sided_R6: assert property (@(posedge clk) disable iff (rst)
    (a_ready || b_ready) |-> (a_valid && b_valid));

  // A taken pair shows up next cycle with matching sample numbers
  assert_pair_emitted_R2: assert property (@(posedge clk) disable iff (rst)
    (a_ready && b_ready) |=> (o_valid && o_frame_a[CW-1:0] == o_frame_b[CW-1:0]));

  // A discard clears the lock flag
  assert_unlock_on_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (a_ready != b_ready) |=> !o_locked);

  // A discard never loads the output register
  assert_drop_no_emit_R3: assert property (@(posedge clk) disable iff (rst)
    ((a_ready != b_ready) && !o_valid) |=> !o_valid);
endmodule

// File: tb/sim_stream_align.sv
module sim_stream_align;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;
  localparam int ND = 2;
  localparam int FW = 2 * SW * (ND + 1);
  localparam int NQ = 48;

  logic clk = 0, rst = 1;
  logic a_valid = 0, b_valid = 0, o_ready = 0;
  logic [FW-1:0] a_frame = '0, b_frame = '0;
  logic a_ready, b_ready, o_valid, o_locked;
  logic [FW-1:0] o_frame_a, o_frame_b;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  stream_align #(.SW(SW), .NDATA(ND), .ALIGN_IVL(0)) u0 (
    .clk(clk), .rst(rst),
    .a_valid(a_valid), .a_ready(a_ready), .a_frame(a_frame),
    .b_valid(b_valid), .b_ready(b_ready), .b_frame(b_frame),
    .o_valid(o_valid), .o_ready(o_ready),
    .o_frame_a(o_frame_a), .o_frame_b(o_frame_b), .o_locked(o_locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [FW-1:0] mk(input logic [31:0] c);
    return {$urandom(), $urandom(), c};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic av, input logic [FW-1:0] fa, input logic bv, input logic [FW-1:0] fb, input logic ordy);
    @(negedge clk);
    a_valid = av; a_frame = fa; b_valid = bv; b_frame = fb; o_ready = ordy;
    #1;
  endtask

  task automatic after_edge;
    @(posedge clk); #1;
  endtask

  logic [FW-1:0] qa [NQ];
  logic [FW-1:0] qb [NQ];
  logic [FW-1:0] ea [NQ];
  logic [FW-1:0] eb [NQ];
  logic [FW-1:0] ga [NQ];
  logic [FW-1:0] gb [NQ];

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] f1, f2;
    int ne, ng, ia, jb;
    bit ha, hb, ho;
    logic [FW-1:0] sa, sb;
    logic [31:0] base, ca, cb;
    void'($urandom(32'd2024));

    // R1 reset
    drive(1, mk(32'd7), 1, mk(32'd7), 1);
    chk(a_ready == 0 && b_ready == 0, "R1 ready in reset", {a_ready, b_ready}, 0);
    after_edge(); after_edge();
    chk(o_valid == 0 && o_locked == 0, "R1 outputs after reset", {o_valid, o_locked}, 0);
    @(negedge clk); rst = 0;

    // R6 single side valid
    drive(1, mk(32'd50), 0, mk(32'd50), 1);
    chk(a_ready == 0 && b_ready == 0, "R6 only A valid", {a_ready, b_ready}, 0);
    after_edge();
    chk(o_valid == 0, "R6 no emit", o_valid, 0);

    // R2 match
    f1 = mk(32'd100); f2 = mk(32'd100);
    drive(1, f1, 1, f2, 1);
    chk(a_ready && b_ready, "R2 both ready", {a_ready, b_ready}, 2'b11);
    after_edge();
    chk(o_valid == 1, "R2 valid", o_valid, 1);
    chk(o_frame_a == f1, "R2 frame A", o_frame_a, f1);
    chk(o_frame_b == f2, "R2 frame B", o_frame_b, f2);
    chk(o_locked == 1, "R8 locked after match", o_locked, 1);

    // R3 A behind
    drive(1, mk(32'd200), 1, mk(32'd205), 1);
    chk(a_ready == 1 && b_ready == 0, "R3 drop A", {a_ready, b_ready}, 2'b10);
    after_edge();
    chk(o_valid == 0, "R3 no emit", o_valid, 0);
    chk(o_locked == 0, "R8 unlock on mismatch", o_locked, 0);

    // R4 B behind
    drive(1, mk(32'd210), 1, mk(32'd205), 1);
    chk(a_ready == 0 && b_ready == 1, "R4 drop B", {a_ready, b_ready}, 2'b01);
    after_edge();

    // R5 wraparound
    drive(1, mk(32'hFFFF_FFF0), 1, mk(32'h0000_0005), 1);
    chk(a_ready == 1 && b_ready == 0, "R5 wrap A behind", {a_ready, b_ready}, 2'b10);
    after_edge();
    drive(1, mk(32'h0000_0003), 1, mk(32'hFFFF_FFFE), 1);
    chk(a_ready == 0 && b_ready == 1, "R5 wrap B behind", {a_ready, b_ready}, 2'b01);
    after_edge();

    // R7 stall
    f1 = mk(32'd300); f2 = mk(32'd300);
    drive(1, f1, 1, f2, 0);
    chk(a_ready && b_ready, "R7 load into empty", {a_ready, b_ready}, 2'b11);
    after_edge();
    drive(1, mk(32'd301), 1, mk(32'd301), 0);
    chk(a_ready == 0 && b_ready == 0, "R7 no accept while stalled", {a_ready, b_ready}, 0);
    after_edge();
    chk(o_valid == 1 && o_frame_a == f1, "R7 output held", o_frame_a, f1);
    drive(1, mk(32'd305), 1, mk(32'd301), 0);
    chk(a_ready == 0 && b_ready == 1, "R3 drop allowed while stalled", {a_ready, b_ready}, 2'b01);
    after_edge();
    chk(o_frame_b == f2, "R7 output B held", o_frame_b, f2);
    drive(0, '0, 0, '0, 1);
    after_edge(); after_edge();

    // R9 random traffic
    base = $urandom();
    ca = base; cb = base + ($urandom() % 11) - 5;
    for (int k = 0; k < NQ; k++) begin
      qa[k] = mk(ca); qb[k] = mk(cb);
      ca = ca + 1 + (($urandom() % 5 == 0) ? ($urandom() % 3) : 0);
      cb = cb + 1 + (($urandom() % 5 == 0) ? ($urandom() % 3) : 0);
    end
    ne = 0; ia = 0; jb = 0;
    while (ia < NQ && jb < NQ) begin
      logic [31:0] d;
      d = qa[ia][31:0] - qb[jb][31:0];
      if (d == 0) begin ea[ne] = qa[ia]; eb[ne] = qb[jb]; ne++; ia++; jb++; end
      else if (d[31]) ia++;
      else jb++;
    end
    ng = 0; ia = 0; jb = 0;
    for (int cyc = 0; cyc < 2000; cyc++) begin
      bit idle;
      idle = (ia >= NQ || jb >= NQ);
      @(negedge clk);
      a_valid = !idle && ($urandom() % 4 != 0);
      b_valid = !idle && ($urandom() % 4 != 0);
      a_frame = qa[(ia < NQ) ? ia : 0];
      b_frame = qb[(jb < NQ) ? jb : 0];
      o_ready = idle || ($urandom() % 4 != 0);
      #1;
      ha = a_valid && a_ready; hb = b_valid && b_ready;
      ho = o_valid && o_ready; sa = o_frame_a; sb = o_frame_b;
      @(posedge clk); #1;
      if (ha) ia++;
      if (hb) jb++;
      if (ho && ng < NQ) begin ga[ng] = sa; gb[ng] = sb; ng++; end
      if (idle && !o_valid) break;
    end
    chk(ng == ne, "R9 pair count", ng, ne);
    for (int k = 0; k < ne && k < ng; k++) begin
      chk(ga[k] == ea[k], "R9 aligned frame A", ga[k], ea[k]);
      chk(gb[k] == eb[k], "R9 aligned frame B", gb[k], eb[k]);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule